// File: doc/BRIEF.md
# Bus-Mapped JTAG Port Bridge

This block lets an embedded processor drive a JTAG chain through a single decoded location on its existing parallel bus, so no spare processor pins are needed. The processor writes a nibble to that address to set the levels of TDI, TMS and TCK, which are held in dedicated registers. It reads the same address to sample TDO and to see, for diagnostics, the three levels it is currently driving. Scan sequences are produced entirely in software by toggling TCK through successive writes.

A selector placed between the pin registers and the chain lets an external download-cable header take over TDI, TMS and TCK. When the cable owns the chain, TDO is passed back to it. The processor registers keep accepting writes but do not reach the pins.

Bus cycles are tracked by a three-state machine. BR_IDLE waits for a qualified cycle. A qualified write goes BR_IDLE to BR_WR_HOLD and loads the registers on that edge. BR_WR_HOLD returns to BR_IDLE once the data strobe is released. A qualified read goes BR_IDLE to BR_RD_DRIVE. BR_RD_DRIVE returns to BR_IDLE as soon as the qualified read ends.

Top module: `jtag_bus_bridge`

## Requirements
- R1: A bus cycle is qualified only when the address equals BASE_ADDR, the address strobe is high and the active-low data strobe is low. Any other cycle changes neither the pin registers nor the read drive.
- R2: On the first clock edge of a qualified write seen in BR_IDLE, TDI takes bus_wdata bit 0, TMS takes bit 1 and TCK takes bit 2. The new levels are visible on the pins after that edge.
- R3: One write strobe loads the registers once. Data changes while the strobe stays low (BR_WR_HOLD) are ignored until bus_ds_n goes high and the machine is back in BR_IDLE.
- R4: While rst_n is low, TDI and TCK are 0, TMS is 1, the machine is in BR_IDLE and the read drive is off.
- R5: With src_cable low, the chain pins follow the processor registers and cab_tdo is held at 1. With src_cable high, the chain pins follow cab_tdi, cab_tms and cab_tck, cab_tdo follows jtag_tdo, and processor writes still load the registers without affecting the pins.
- R6: After the edge that sees a qualified read in BR_IDLE, bus_oe is 1 and bus_rdata carries TDI on bit 0, TMS on bit 1, TCK on bit 2 and the live jtag_tdo on bit 3.
- R7: One cycle after the qualified read ends, bus_oe returns to 0 and bus_rdata to 0.
- R8: A read to any address other than BASE_ADDR never raises bus_oe, and bus_rdata stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_as | input | 1 | Address strobe, active high |
| bus_ds_n | input | 1 | Data strobe, active low |
| bus_rnw | input | 1 | 1 = read, 0 = write |
| bus_wdata | input | 4 | Write data slice |
| bus_rdata | output | 4 | Read data slice |
| bus_oe | output | 1 | High while the block drives the read data |
| src_cable | input | 1 | 0 = processor owns the chain, 1 = cable owns it |
| cab_tdi | input | 1 | Cable TDI |
| cab_tms | input | 1 | Cable TMS |
| cab_tck | input | 1 | Cable TCK |
| cab_tdo | output | 1 | TDO returned to the cable |
| jtag_tdi | output | 1 | Chain TDI |
| jtag_tms | output | 1 | Chain TMS |
| jtag_tck | output | 1 | Chain TCK |
| jtag_tdo | input | 1 | Chain TDO |

## Verification
The bench builds the block with the default 20-bit address and BASE_ADDR of 20'hA5C30. This lets it probe near-miss addresses that differ in a single high or low bit from the match value. A behavioural model tracks the bus phase and the three pin levels and is compared with every output on every cycle. The stimulus covers held strobes with changing data, reads with TDO toggling mid-cycle, ownership switches during writes, and a reset applied in the middle of a held write.

// File: rtl/jtag_bridge_pkg.sv
package jtag_bridge_pkg;
    localparam int PIN_N    = 3;
    localparam int NIB_W    = 4;
    localparam int TDI_BIT  = 0;
    localparam int TMS_BIT  = 1;
    localparam int TCK_BIT  = 2;
    localparam int TDO_BIT  = 3;
    localparam logic [PIN_N-1:0] PIN_RESET = 3'b010;

    typedef enum logic [1:0] {
        BR_IDLE,
        BR_WR_HOLD,
        BR_RD_DRIVE
    } br_state_e;
endpackage

// File: rtl/bridge_bus_fsm.sv
module bridge_bus_fsm
    import jtag_bridge_pkg::*;
#(
    parameter int          ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 20'hA5C30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              as_i,
    input  logic              ds_n,
    input  logic              rnw,
    output logic              wr_en,
    output logic              rd_oe
);
    br_state_e state_q, state_d;
    logic      hit;

    assign hit = as_i && !ds_n && (addr == BASE_ADDR);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BR_IDLE: begin
                if (hit && !rnw)      state_d = BR_WR_HOLD;
                else if (hit && rnw)  state_d = BR_RD_DRIVE;
            end
            BR_WR_HOLD:  if (ds_n)          state_d = BR_IDLE;
            BR_RD_DRIVE: if (!(hit && rnw)) state_d = BR_IDLE;
            default:                        state_d = BR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BR_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        wr_en = 1'b0;
        rd_oe = 1'b0;
        unique case (state_q)
            BR_IDLE:     wr_en = hit && !rnw;
            BR_WR_HOLD:  wr_en = 1'b0;
            BR_RD_DRIVE: rd_oe = 1'b1;
            default:     wr_en = 1'b0;
        endcase
    end

    assert_hold_no_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == BR_WR_HOLD) |-> !wr_en);
    assert_drive_only_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_oe |-> $past(rnw));
    assert_no_match_no_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> !rd_oe);
endmodule

// File: rtl/bridge_pin_regs.sv
module bridge_pin_regs
    import jtag_bridge_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [NIB_W-1:0] wr_data,
    output logic [PIN_N-1:0] pin_q
);
    for (genvar g = 0; g < PIN_N; g++) begin : g_pin
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     pin_q[g] <= PIN_RESET[g];
            else if (wr_en) pin_q[g] <= wr_data[g];
        end
    end

    assert_write_loads_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (pin_q == $past(wr_data[PIN_N-1:0])));
    assert_stable_no_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pin_q));
endmodule

// File: rtl/bridge_chain_mux.sv
module bridge_chain_mux
    import jtag_bridge_pkg::*;
(
    input  logic             src_cable,
    input  logic [PIN_N-1:0] proc_pins,
    input  logic [PIN_N-1:0] cab_pins,
    input  logic             chain_tdo,
    output logic [PIN_N-1:0] chain_pins,
    output logic             cab_tdo
);
    for (genvar g = 0; g < PIN_N; g++) begin : g_lane
        assign chain_pins[g] = src_cable ? cab_pins[g] : proc_pins[g];
    end
    assign cab_tdo = src_cable ? chain_tdo : 1'b1;
endmodule

// File: rtl/jtag_bus_bridge.sv
module jtag_bus_bridge
    import jtag_bridge_pkg::*;
#(
    parameter int          ADDR_W    = 20,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 20'hA5C30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_as,
    input  logic              bus_ds_n,
    input  logic              bus_rnw,
    input  logic [3:0]        bus_wdata,
    output logic [3:0]        bus_rdata,
    output logic              bus_oe,
    input  logic              src_cable,
    input  logic              cab_tdi,
    input  logic              cab_tms,
    input  logic              cab_tck,
    output logic              cab_tdo,
    output logic              jtag_tdi,
    output logic              jtag_tms,
    output logic              jtag_tck,
    input  logic              jtag_tdo
);
    logic             wr_en;
    logic             rd_oe;
    logic [PIN_N-1:0] pin_q;
    logic [PIN_N-1:0] cab_pins;
    logic [PIN_N-1:0] chain_pins;

    bridge_bus_fsm #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .addr(bus_addr), .as_i(bus_as),
        .ds_n(bus_ds_n), .rnw(bus_rnw), .wr_en(wr_en), .rd_oe(rd_oe)
    );

    bridge_pin_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(bus_wdata), .pin_q(pin_q)
    );

    assign cab_pins[TDI_BIT] = cab_tdi;
    assign cab_pins[TMS_BIT] = cab_tms;
    assign cab_pins[TCK_BIT] = cab_tck;

    bridge_chain_mux u_mux (
        .src_cable(src_cable), .proc_pins(pin_q), .cab_pins(cab_pins),
        .chain_tdo(jtag_tdo), .chain_pins(chain_pins), .cab_tdo(cab_tdo)
    );

    assign jtag_tdi = chain_pins[TDI_BIT];
    assign jtag_tms = chain_pins[TMS_BIT];
    assign jtag_tck = chain_pins[TCK_BIT];

    assign bus_oe    = rd_oe;
    assign bus_rdata = rd_oe ? {jtag_tdo, pin_q} : '0;

    assert_read_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (bus_rdata[TDO_BIT] == jtag_tdo));
endmodule

// File: tb/test_jtag_bus_bridge.sv
module test_jtag_bus_bridge;
    localparam logic [19:0] BASE = 20'hA5C30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [19:0] bus_addr = '0;
    logic        bus_as = 1'b0, bus_ds_n = 1'b1, bus_rnw = 1'b1;
    logic [3:0]  bus_wdata = '0;
    logic [3:0]  bus_rdata;
    logic        bus_oe;
    logic        src_cable = 1'b0, cab_tdi = 1'b0, cab_tms = 1'b0, cab_tck = 1'b0;
    logic        cab_tdo, jtag_tdi, jtag_tms, jtag_tck;
    logic        jtag_tdo = 1'b0;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    int m_phase = 0;
    bit m_tdi = 1'b0, m_tms = 1'b1, m_tck = 1'b0;

    always #5 clk = ~clk;

    jtag_bus_bridge i_jtag_bus_bridge (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_as(bus_as),
        .bus_ds_n(bus_ds_n), .bus_rnw(bus_rnw), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_oe(bus_oe), .src_cable(src_cable),
        .cab_tdi(cab_tdi), .cab_tms(cab_tms), .cab_tck(cab_tck), .cab_tdo(cab_tdo),
        .jtag_tdi(jtag_tdi), .jtag_tms(jtag_tms), .jtag_tck(jtag_tck), .jtag_tdo(jtag_tdo)
    );

    // reference model: bus phase 0 idle, 1 write held, 2 read driving
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_tdi = 1'b0; m_tms = 1'b1; m_tck = 1'b0;
        end else begin
            bit q;
            q = bus_as && !bus_ds_n && (bus_addr == BASE);
            if (m_phase == 0) begin
                if (q && !bus_rnw) begin
                    m_tdi = bus_wdata[0]; m_tms = bus_wdata[1]; m_tck = bus_wdata[2];
                    m_phase = 1;
                end else if (q && bus_rnw) m_phase = 2;
            end else if (m_phase == 1) begin
                if (bus_ds_n) m_phase = 0;
            end else begin
                if (!(q && bus_rnw)) m_phase = 0;
            end
        end
    end

    task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
        end
    endtask

    always @(negedge clk) begin
        bit e_oe;
        logic [3:0] e_rd;
        logic [2:0] e_pins;
        e_oe   = (m_phase == 2);
        e_rd   = e_oe ? {jtag_tdo, m_tck, m_tms, m_tdi} : 4'h0;
        e_pins = src_cable ? {cab_tck, cab_tms, cab_tdi} : {m_tck, m_tms, m_tdi};
        chk("R2/R3/R4/R5 chain pins", {1'b0, jtag_tck, jtag_tms, jtag_tdi}, {1'b0, e_pins});
        chk("R5 cable tdo", {3'b0, cab_tdo}, {3'b0, src_cable ? jtag_tdo : 1'b1});
        chk("R1/R4/R7/R8 bus_oe", {3'b0, bus_oe}, {3'b0, e_oe});
        chk("R6/R7/R8 bus_rdata", bus_rdata, e_rd);
    end

    task automatic at_step();
        @(posedge clk); #3;
    endtask

    task automatic cyc(logic [19:0] a, bit as_v, bit rnw, logic [3:0] d);
        bus_addr = a; bus_as = as_v; bus_ds_n = 1'b0; bus_rnw = rnw; bus_wdata = d;
    endtask

    task automatic idle_bus();
        bus_as = 1'b0; bus_ds_n = 1'b1; bus_rnw = 1'b1;
    endtask

    // R2, R3: write held three cycles, data changed mid-strobe
    task automatic bus_write(logic [19:0] a, logic [3:0] d);
        at_step(); cyc(a, 1'b1, 1'b0, d);
        at_step(); bus_wdata = ~d;
        at_step(); bus_wdata = d ^ 4'h5;
        at_step(); idle_bus();
        at_step();
    endtask

    // R6, R7: read with TDO toggling
    task automatic bus_read(logic [19:0] a);
        at_step(); cyc(a, 1'b1, 1'b1, 4'h0);
        at_step(); jtag_tdo = ~jtag_tdo;
        at_step(); jtag_tdo = ~jtag_tdo;
        at_step(); idle_bus();
        at_step();
    endtask

    initial begin
        repeat (3) at_step();               // R4 reset state compared each cycle
        rst_n = 1'b1;
        at_step();
        bus_write(BASE, 4'h5);              // R2 TDI=1 TCK=1 TMS=0
        bus_read(BASE);                     // R6
        bus_write(BASE, 4'hA);              // R2 TMS=1 only
        bus_read(BASE);
        bus_write(BASE ^ 20'h80000, 4'h7);  // R1 high-bit miss
        bus_write(BASE ^ 20'h00001, 4'h7);  // R1 low-bit miss
        at_step(); cyc(BASE, 1'b0, 1'b0, 4'h7); // R1 no address strobe
        at_step(); at_step(); idle_bus(); at_step();
        bus_read(BASE ^ 20'h00010);         // R8
        bus_read(BASE);
        src_cable = 1'b1; cab_tdi = 1'b1; cab_tms = 1'b0; cab_tck = 1'b1; jtag_tdo = 1'b1;
        bus_write(BASE, 4'h3);              // R5 register loads, pins follow cable
        at_step(); cab_tck = 1'b0; jtag_tdo = 1'b0;
        at_step(); src_cable = 1'b0;        // R5 registers show the cable-time write
        bus_read(BASE);
        for (int i = 0; i < 8; i++) bus_write(BASE, 4'(i));
        // back-to-back read after write without idle gap
        at_step(); cyc(BASE, 1'b1, 1'b0, 4'h6);
        at_step(); bus_ds_n = 1'b1;
        at_step(); cyc(BASE, 1'b1, 1'b1, 4'h0);
        at_step(); at_step(); idle_bus(); at_step();
        // R4 reset during held write
        at_step(); cyc(BASE, 1'b1, 1'b0, 4'h1);
        at_step(); rst_n = 1'b0;
        at_step(); at_step(); idle_bus(); rst_n = 1'b1;
        at_step(); at_step();
        bus_read(BASE);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule